// File: doc/BRIEF.md
# PTP Local Time Base with Periodic Sync Pulse

This block holds the local precision-time clock of a network node as two registers: a nanosecond count that advances by a fixed increment on every clock and returns to zero once a full second has elapsed, and a 48-bit seconds count that takes the carry from each such wrap. With the default parameters the increment is 5 ns, which matches a 200 MHz clock. A one-cycle tick output marks every forward carry into the seconds count.

Software sets the time in two ways. A load writes both halves at once; this is the initial adjustment, and the block records that it has happened until reset. A signed step adds a small offset to the nanosecond count, carrying into or borrowing from the seconds count when the result leaves the range of one second. A snapshot request captures both halves from the same clock edge, so a reader never sees a seconds value from one side of a wrap paired with a nanosecond value from the other.

A compare unit produces a periodic output pulse locked to the nanosecond count. The first compare point is the top of the second. After each hit the next compare point is placed one period later, modulo one second. The period is held between a minimum and a maximum (1 ms and 1 s by default), and the pulse width is configured separately.

Top module: `ptp_timebase`

## Requirements
- R1: During and straight after reset, `tm_ns`, `tm_sec`, `sec_tick`, `set_done`, `snap_valid` and `pps_out` are all 0, and `tm_ns` never reaches `NS_PER_SEC`.
- R2: When no load or step is presented and `tm_ns` is below `NS_PER_SEC - STEP`, `tm_ns` grows by `STEP` at the next clock edge.
- R3: When `tm_ns` is at or above `NS_PER_SEC - STEP` with no load or step, the next edge sets `tm_ns` to 0, increments the 48-bit `tm_sec` (wrapping from all ones to 0), and raises `sec_tick` for exactly that one cycle.
- R4: A cycle with `set_valid` high loads `tm_sec` from `set_sec` and `tm_ns` from `set_ns`. The loaded nanoseconds are first limited to `NS_PER_SEC - STEP` and then rounded down to a multiple of `STEP`. A load takes priority over a simultaneous step. `set_done` rises with the first load and stays high until reset.
- R5: A cycle with `step_valid` (and no load) computes t = `tm_ns` + `STEP` + `step_ns`, where `step_ns` is two's complement. If t ≥ `NS_PER_SEC`, the new value is t − `NS_PER_SEC`, `tm_sec` increments and `sec_tick` rises. If t < 0, the new value is t + `NS_PER_SEC` and `tm_sec` decrements. The result is then rounded down to a multiple of `STEP`.
- R6: A cycle with `snap_req` high makes `snap_valid` high in the next cycle. In that cycle `snap_sec`/`snap_ns` equal the `tm_sec`/`tm_ns` values present in the request cycle. The snapshot outputs hold until the next request.
- R7: When `pps_en` goes from 0 to 1, the compare point is set to 0. In any later cycle with `pps_en` high in which `tm_ns` equals the compare point, `pps_out` goes high from the next cycle for ceil(W/`STEP`) cycles, where W is the clamped width.
- R8: At every hit the compare point advances by the clamped period P, modulo `NS_PER_SEC`. With free counting, successive rising edges of `pps_out` are therefore P/`STEP` cycles apart, including across a second boundary.
- R9: P is `pps_period` limited to [`PER_MIN`, `PER_MAX`] and rounded down to a multiple of `STEP`. W is `pps_width` limited to [`STEP`, P − `STEP`].
- R10: While `pps_en` is low, `pps_out` is low from the next cycle on and no pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Load the time from set_sec/set_ns this cycle |
| set_sec | input | SEC_W | Seconds value to load |
| set_ns | input | NS_W | Nanoseconds value to load |
| step_valid | input | 1 | Apply a signed nanosecond step this cycle |
| step_ns | input | ADJ_W | Signed step amount in nanoseconds |
| pps_en | input | 1 | Enable the periodic pulse |
| pps_period | input | NS_W | Requested pulse period in nanoseconds |
| pps_width | input | NS_W | Requested pulse width in nanoseconds |
| snap_req | input | 1 | Capture both time halves at this edge |
| tm_sec | output | SEC_W | Current seconds |
| tm_ns | output | NS_W | Current nanoseconds |
| sec_tick | output | 1 | One-cycle marker of a forward carry into seconds |
| set_done | output | 1 | An initial load has happened since reset |
| snap_valid | output | 1 | Snapshot outputs were updated this cycle |
| snap_sec | output | SEC_W | Captured seconds |
| snap_ns | output | NS_W | Captured nanoseconds |
| pps_out | output | 1 | Periodic sync pulse |

## Verification
On every cycle the assertions check the following: the nanosecond range, the plain advance by one increment, the seconds count rising on each tick, the load flag never dropping, the snapshot pairing with the previous cycle's time, and the pulse staying low while disabled. Some behaviour only the bench's scenarios can show. This includes the rounding and limiting of loaded and stepped values, borrow versus carry on a step, the 48-bit seconds wrap, the priority of load over step, and the period and width clamping. It also includes the spacing of pulse edges across second boundaries. The bench shows these by comparing against a behavioural model on every clock and by directed checks with known values.

// File: rtl/ptpt_pkg.sv
package ptpt_pkg;

   typedef enum logic [1:0] {
      UPD_COUNT = 2'd0,
      UPD_LOAD  = 2'd1,
      UPD_STEP  = 2'd2
   } upd_e;

   function automatic logic [63:0] clamp_u64(input logic [63:0] v,
                                             input logic [63:0] lo,
                                             input logic [63:0] hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction

endpackage

// File: rtl/ptpt_floor.sv
// Rounds an unsigned value down to a multiple of STEP.
module ptpt_floor #(
   parameter int W    = 32,
   parameter int STEP = 5
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam logic [W-1:0] STEP_V = W'(STEP);
   localparam logic [W-1:0] LOW_M  = W'(STEP - 1);
   localparam bit           POW2   = ((STEP & (STEP - 1)) == 0);

   generate
      if (POW2) begin : g_mask
         assign dout = din & ~LOW_M;
      end else begin : g_mod
         assign dout = din - (din % STEP_V);
      end
   endgenerate
endmodule

// File: rtl/ptpt_clock.sv
// Nanosecond / seconds counter with load and signed step.
module ptpt_clock import ptpt_pkg::*; #(
   parameter int NS_W       = 32,
   parameter int SEC_W      = 48,
   parameter int ADJ_W      = 30,
   parameter int STEP       = 5,
   parameter int NS_PER_SEC = 1_000_000_000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_valid,
   input  logic [SEC_W-1:0]        set_sec,
   input  logic [NS_W-1:0]         set_ns,
   input  logic                    step_valid,
   input  logic signed [ADJ_W-1:0] step_ns,
   output logic [NS_W-1:0]         ns_q,
   output logic [SEC_W-1:0]        sec_q,
   output logic                    tick_q,
   output logic                    done_q
);
   localparam int                CW      = NS_W + 2;
   localparam logic [NS_W-1:0]   LAST_NS = NS_W'(NS_PER_SEC - STEP);
   localparam logic [NS_W-1:0]   STEP_NS = NS_W'(STEP);
   localparam logic [SEC_W-1:0]  SEC_ONE = SEC_W'(1);
   localparam logic signed [CW-1:0] LIM_S  = CW'(NS_PER_SEC);
   localparam logic signed [CW-1:0] STEP_S = CW'(STEP);

   upd_e                   mode;
   logic [NS_W-1:0]        set_cl;
   logic [NS_W-1:0]        set_fl;
   logic [NS_W-1:0]        step_raw;
   logic [NS_W-1:0]        step_fl;
   logic signed [CW-1:0]   step_x;
   logic signed [CW-1:0]   sum_s;
   logic signed [CW-1:0]   wrap_s;
   logic                   carry;
   logic                   borrow;
   logic                   wrap_run;

   always_comb begin
      if (set_valid)       mode = UPD_LOAD;
      else if (step_valid) mode = UPD_STEP;
      else                 mode = UPD_COUNT;
   end

   // load path: limit, then round
   assign set_cl = (set_ns > LAST_NS) ? LAST_NS : set_ns;

   ptpt_floor #(.W(NS_W), .STEP(STEP)) u_set_fl (
      .din  (set_cl),
      .dout (set_fl)
   );

   // step path: signed sum, wrap into one second, round
   assign step_x = $signed({{(CW-ADJ_W){step_ns[ADJ_W-1]}}, step_ns});
   assign sum_s  = $signed({2'b00, ns_q}) + STEP_S + step_x;
   assign carry  = (sum_s >= LIM_S);
   assign borrow = (sum_s < 0);

   always_comb begin
      if (carry)       wrap_s = sum_s - LIM_S;
      else if (borrow) wrap_s = sum_s + LIM_S;
      else             wrap_s = sum_s;
   end

   assign step_raw = wrap_s[NS_W-1:0];

   ptpt_floor #(.W(NS_W), .STEP(STEP)) u_step_fl (
      .din  (step_raw),
      .dout (step_fl)
   );

   // one-second compare event
   assign wrap_run = (ns_q >= LAST_NS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q   <= '0;
         sec_q  <= '0;
         tick_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         unique case (mode)
            UPD_LOAD: begin
               ns_q   <= set_fl;
               sec_q  <= set_sec;
               done_q <= 1'b1;
            end
            UPD_STEP: begin
               ns_q <= step_fl;
               if (carry) begin
                  sec_q  <= sec_q + SEC_ONE;
                  tick_q <= 1'b1;
               end else if (borrow) begin
                  sec_q <= sec_q - SEC_ONE;
               end
            end
            default: begin
               if (wrap_run) begin
                  ns_q   <= '0;
                  sec_q  <= sec_q + SEC_ONE;
                  tick_q <= 1'b1;
               end else begin
                  ns_q <= ns_q + STEP_NS;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ptpt_pulse.sv
// Self-rearming compare unit producing the periodic pulse.
module ptpt_pulse import ptpt_pkg::*; #(
   parameter int NS_W       = 32,
   parameter int STEP       = 5,
   parameter int NS_PER_SEC = 1_000_000_000,
   parameter int PER_MIN    = 1_000_000,
   parameter int PER_MAX    = 1_000_000_000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [NS_W-1:0] period,
   input  logic [NS_W-1:0] width,
   input  logic [NS_W-1:0] ns,
   output logic            pulse
);
   localparam logic [63:0]     MIN64  = 64'(PER_MIN);
   localparam logic [63:0]     MAX64  = 64'(PER_MAX);
   localparam logic [63:0]     STEP64 = 64'(STEP);
   localparam logic [NS_W-1:0] STEP_N = NS_W'(STEP);
   localparam logic [NS_W:0]   LIM_X  = (NS_W+1)'(NS_PER_SEC);

   logic [NS_W-1:0] per_cl;
   logic [NS_W-1:0] per_c;
   logic [NS_W-1:0] wid_c;
   logic [NS_W-1:0] cmp_q;
   logic [NS_W-1:0] rem_q;
   logic [NS_W:0]   nxt_x;
   logic            en_q;
   logic            arm;
   logic            hit;

   assign per_cl = NS_W'(clamp_u64(64'(period), MIN64, MAX64));

   ptpt_floor #(.W(NS_W), .STEP(STEP)) u_per_fl (
      .din  (per_cl),
      .dout (per_c)
   );

   assign wid_c = NS_W'(clamp_u64(64'(width), STEP64, 64'(per_c) - STEP64));

   assign arm = en && !en_q;
   assign hit = en && en_q && (ns == cmp_q);

   always_comb begin
      nxt_x = {1'b0, cmp_q} + {1'b0, per_c};
      if (nxt_x >= LIM_X) nxt_x = nxt_x - LIM_X;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         cmp_q <= '0;
         rem_q <= '0;
      end else begin
         en_q <= en;
         if (arm)      cmp_q <= '0;
         else if (hit) cmp_q <= nxt_x[NS_W-1:0];

         if (!en)                 rem_q <= '0;
         else if (hit)            rem_q <= wid_c;
         else if (rem_q > STEP_N) rem_q <= rem_q - STEP_N;
         else                     rem_q <= '0;
      end
   end

   assign pulse = |rem_q;
endmodule

// File: rtl/ptpt_snap.sv
// Coherent capture of both time halves.
module ptpt_snap #(
   parameter int NS_W  = 32,
   parameter int SEC_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [NS_W-1:0]  ns,
   input  logic [SEC_W-1:0] sec,
   output logic             valid_q,
   output logic [NS_W-1:0]  ns_q,
   output logic [SEC_W-1:0] sec_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ns_q    <= '0;
         sec_q   <= '0;
      end else begin
         valid_q <= req;
         if (req) begin
            ns_q  <= ns;
            sec_q <= sec;
         end
      end
   end
endmodule

// File: rtl/ptp_timebase.sv
module ptp_timebase #(
   parameter int NS_W       = 32,
   parameter int SEC_W      = 48,
   parameter int ADJ_W      = 30,
   parameter int STEP       = 5,
   parameter int NS_PER_SEC = 1_000_000_000,
   parameter int PER_MIN    = 1_000_000,
   parameter int PER_MAX    = 1_000_000_000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_valid,
   input  logic [SEC_W-1:0]        set_sec,
   input  logic [NS_W-1:0]         set_ns,
   input  logic                    step_valid,
   input  logic signed [ADJ_W-1:0] step_ns,
   input  logic                    pps_en,
   input  logic [NS_W-1:0]         pps_period,
   input  logic [NS_W-1:0]         pps_width,
   input  logic                    snap_req,
   output logic [SEC_W-1:0]        tm_sec,
   output logic [NS_W-1:0]         tm_ns,
   output logic                    sec_tick,
   output logic                    set_done,
   output logic                    snap_valid,
   output logic [SEC_W-1:0]        snap_sec,
   output logic [NS_W-1:0]         snap_ns,
   output logic                    pps_out
);
   // elaboration-time parameter checks
   generate
      if (STEP < 1 || (NS_PER_SEC % STEP) != 0) begin : g_bad_step
         $error("ptp_timebase: NS_PER_SEC must be a positive multiple of STEP");
      end
      if (longint'(NS_PER_SEC) >= (longint'(1) << NS_W)) begin : g_bad_nsw
         $error("ptp_timebase: NS_W too narrow for NS_PER_SEC");
      end
      if (ADJ_W >= NS_W ||
          (longint'(1) << (ADJ_W - 1)) > longint'(NS_PER_SEC - STEP)) begin : g_bad_adj
         $error("ptp_timebase: step range must stay below one second");
      end
      if (PER_MIN < 2 * STEP || PER_MAX > NS_PER_SEC || PER_MIN > PER_MAX ||
          (PER_MIN % STEP) != 0 || (PER_MAX % STEP) != 0) begin : g_bad_per
         $error("ptp_timebase: pulse period limits inconsistent");
      end
      if (SEC_W < 1 || SEC_W > 63) begin : g_bad_sec
         $error("ptp_timebase: SEC_W out of range");
      end
   endgenerate

   ptpt_clock #(
      .NS_W(NS_W), .SEC_W(SEC_W), .ADJ_W(ADJ_W),
      .STEP(STEP), .NS_PER_SEC(NS_PER_SEC)
   ) u_clock (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_valid  (set_valid),
      .set_sec    (set_sec),
      .set_ns     (set_ns),
      .step_valid (step_valid),
      .step_ns    (step_ns),
      .ns_q       (tm_ns),
      .sec_q      (tm_sec),
      .tick_q     (sec_tick),
      .done_q     (set_done)
   );

   ptpt_pulse #(
      .NS_W(NS_W), .STEP(STEP), .NS_PER_SEC(NS_PER_SEC),
      .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
   ) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (pps_en),
      .period (pps_period),
      .width  (pps_width),
      .ns     (tm_ns),
      .pulse  (pps_out)
   );

   ptpt_snap #(.NS_W(NS_W), .SEC_W(SEC_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (snap_req),
      .ns      (tm_ns),
      .sec     (tm_sec),
      .valid_q (snap_valid),
      .ns_q    (snap_ns),
      .sec_q   (snap_sec)
   );
endmodule

// File: rtl/ptp_timebase_chk.sv
module ptp_timebase_chk #(
   parameter int NS_W       = 32,
   parameter int SEC_W      = 48,
   parameter int ADJ_W      = 30,
   parameter int STEP       = 5,
   parameter int NS_PER_SEC = 1_000_000_000
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    set_valid,
   input logic [SEC_W-1:0]        set_sec,
   input logic [NS_W-1:0]         set_ns,
   input logic                    step_valid,
   input logic signed [ADJ_W-1:0] step_ns,
   input logic                    pps_en,
   input logic [NS_W-1:0]         pps_period,
   input logic [NS_W-1:0]         pps_width,
   input logic                    snap_req,
   input logic [SEC_W-1:0]        tm_sec,
   input logic [NS_W-1:0]         tm_ns,
   input logic                    sec_tick,
   input logic                    set_done,
   input logic                    snap_valid,
   input logic [SEC_W-1:0]        snap_sec,
   input logic [NS_W-1:0]         snap_ns,
   input logic                    pps_out
);
   // R1
   ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tm_ns < NS_W'(NS_PER_SEC));

   // R2
   count_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(set_valid) && !$past(step_valid) && !sec_tick)
      |-> (tm_ns == $past(tm_ns) + NS_W'(STEP)));

   // R3
   tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (tm_sec == $past(tm_sec) + SEC_W'(1)));

   // R4
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |=> set_done);

   // R6
   snap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (snap_valid == $past(snap_req)));

   // R6
   snap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |-> (snap_ns == $past(tm_ns) && snap_sec == $past(tm_sec)));

   // R10
   pps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pps_en |=> !pps_out);
endmodule

bind ptp_timebase ptp_timebase_chk #(
   .NS_W(NS_W), .SEC_W(SEC_W), .ADJ_W(ADJ_W),
   .STEP(STEP), .NS_PER_SEC(NS_PER_SEC)
) u_chk (.*);

// File: tb/ptp_timebase_bench.sv
`timescale 1ns/1ps
module ptp_timebase_bench;
   localparam int NS_W  = 32;
   localparam int SEC_W = 48;
   localparam int ADJ_W = 10;
   localparam int STEP  = 5;
   localparam int LIM   = 1000;
   localparam int PMIN  = 50;
   localparam int PMAX  = 1000;
   localparam longint SEC_MASK = (longint'(1) << SEC_W) - 1;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    set_valid = 1'b0;
   logic [SEC_W-1:0]        set_sec = '0;
   logic [NS_W-1:0]         set_ns = '0;
   logic                    step_valid = 1'b0;
   logic signed [ADJ_W-1:0] step_ns = '0;
   logic                    pps_en = 1'b0;
   logic [NS_W-1:0]         pps_period = 32'd100;
   logic [NS_W-1:0]         pps_width = 32'd10;
   logic                    snap_req = 1'b0;
   logic [SEC_W-1:0]        tm_sec;
   logic [NS_W-1:0]         tm_ns;
   logic                    sec_tick;
   logic                    set_done;
   logic                    snap_valid;
   logic [SEC_W-1:0]        snap_sec;
   logic [NS_W-1:0]         snap_ns;
   logic                    pps_out;

   always #2 clk = ~clk;

   ptp_timebase #(
      .NS_W(NS_W), .SEC_W(SEC_W), .ADJ_W(ADJ_W), .STEP(STEP),
      .NS_PER_SEC(LIM), .PER_MIN(PMIN), .PER_MAX(PMAX)
   ) u_ptp_timebase (.*);

   int errors = 0;
   int checks = 0;

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   longint m_ns = 0, m_sec = 0, m_snn = 0, m_sns = 0, m_cmp = 0, m_rem = 0;
   bit     m_tick = 0, m_done = 0, m_snv = 0, m_enq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ns = 0; m_sec = 0; m_tick = 0; m_done = 0;
         m_snv = 0; m_snn = 0; m_sns = 0;
         m_cmp = 0; m_rem = 0; m_enq = 0;
      end else begin
         longint p, w, t;
         bit hit;
         m_snv = snap_req;
         if (snap_req) begin m_sns = m_sec; m_snn = m_ns; end
         p = longint'(pps_period);
         if (p < PMIN) p = PMIN;
         if (p > PMAX) p = PMAX;
         p = p - (p % STEP);
         w = longint'(pps_width);
         if (w < STEP) w = STEP;
         if (w > p - STEP) w = p - STEP;
         hit = pps_en && m_enq && (m_ns == m_cmp);
         if (!pps_en)         m_rem = 0;
         else if (hit)        m_rem = w;
         else if (m_rem > STEP) m_rem = m_rem - STEP;
         else                 m_rem = 0;
         if (pps_en && !m_enq) m_cmp = 0;
         else if (hit) begin
            m_cmp = m_cmp + p;
            if (m_cmp >= LIM) m_cmp = m_cmp - LIM;
         end
         m_enq = pps_en;
         m_tick = 0;
         if (set_valid) begin
            t = longint'(set_ns);
            if (t > LIM - STEP) t = LIM - STEP;
            m_ns = t - (t % STEP);
            m_sec = longint'(set_sec);
            m_done = 1;
         end else if (step_valid) begin
            t = m_ns + STEP + longint'(step_ns);
            if (t >= LIM) begin t = t - LIM; m_sec = (m_sec + 1) & SEC_MASK; m_tick = 1; end
            else if (t < 0) begin t = t + LIM; m_sec = (m_sec - 1) & SEC_MASK; end
            m_ns = t - (t % STEP);
         end else if (m_ns >= LIM - STEP) begin
            m_ns = 0; m_sec = (m_sec + 1) & SEC_MASK; m_tick = 1;
         end else begin
            m_ns = m_ns + STEP;
         end
      end
   end

   // compare against the model away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "model tm_ns", longint'(tm_ns), m_ns);
         chk("R3", "model tm_sec", longint'(tm_sec), m_sec);
         chk("R3", "model sec_tick", longint'(sec_tick), longint'(m_tick));
         chk("R4", "model set_done", longint'(set_done), longint'(m_done));
         chk("R6", "model snap_valid", longint'(snap_valid), longint'(m_snv));
         chk("R6", "model snap_ns", longint'(snap_ns), m_snn);
         chk("R6", "model snap_sec", longint'(snap_sec), m_sns);
         chk("R7", "model pps_out", longint'(pps_out), longint'(m_rem != 0));
      end
   end

   // pulse edge monitor
   longint cyc = 0, last_rise = 0, last_gap = 0, rises = 0;
   int     hi_cnt = 0, last_hi = 0;
   bit     prev_p = 0;
   always @(posedge clk) cyc++;
   always @(negedge clk) begin
      if (pps_out && !prev_p) begin
         if (rises != 0) last_gap = cyc - last_rise;
         last_rise = cyc;
         rises++;
      end
      if (pps_out) hi_cnt++;
      else if (prev_p) begin last_hi = hi_cnt; hi_cnt = 0; end
      prev_p = pps_out;
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic load(input longint s, input longint n);
      set_valid = 1'b1; set_sec = SEC_W'(s); set_ns = NS_W'(n);
      tick();
      set_valid = 1'b0;
   endtask

   initial begin
      longint es, en;
      longint r0;
      repeat (3) tick();
      // R1: reset state
      chk("R1", "reset tm_ns", longint'(tm_ns), 0);
      chk("R1", "reset tm_sec", longint'(tm_sec), 0);
      chk("R1", "reset set_done", longint'(set_done), 0);
      chk("R1", "reset pps_out", longint'(pps_out), 0);
      chk("R1", "reset snap_valid", longint'(snap_valid), 0);
      rst_n = 1'b1;
      tick();
      chk("R2", "first advance", longint'(tm_ns), 5);
      repeat (199) tick();
      chk("R3", "wrap ns", longint'(tm_ns), 0);
      chk("R3", "wrap sec", longint'(tm_sec), 1);
      chk("R3", "wrap tick", longint'(sec_tick), 1);
      tick();
      chk("R3", "tick one cycle", longint'(sec_tick), 0);

      // R6 snapshot
      snap_req = 1'b1; es = longint'(tm_sec); en = longint'(tm_ns);
      tick();
      snap_req = 1'b0;
      chk("R6", "snap valid", longint'(snap_valid), 1);
      chk("R6", "snap ns", longint'(snap_ns), en);
      chk("R6", "snap sec", longint'(snap_sec), es);

      // R4 load with rounding, then R3 48-bit wrap
      load(SEC_MASK, 992);
      chk("R4", "load ns rounded", longint'(tm_ns), 990);
      chk("R4", "load sec", longint'(tm_sec), SEC_MASK);
      chk("R4", "set_done", longint'(set_done), 1);
      tick(); tick();
      chk("R3", "48-bit sec wrap", longint'(tm_sec), 0);
      chk("R3", "48-bit wrap tick", longint'(sec_tick), 1);
      load(3, 5000);
      chk("R4", "load ns limited", longint'(tm_ns), 995);
      // R4 load wins over step
      set_valid = 1'b1; set_sec = 48'd7; set_ns = 32'd100;
      step_valid = 1'b1; step_ns = ADJ_W'(300);
      tick();
      set_valid = 1'b0; step_valid = 1'b0;
      chk("R4", "load priority ns", longint'(tm_ns), 100);
      chk("R4", "load priority sec", longint'(tm_sec), 7);

      // R5 step carry
      load(10, 990);
      step_valid = 1'b1; step_ns = ADJ_W'(20);
      tick();
      step_valid = 1'b0;
      chk("R5", "step carry ns", longint'(tm_ns), 15);
      chk("R5", "step carry sec", longint'(tm_sec), 11);
      chk("R5", "step carry tick", longint'(sec_tick), 1);
      // R5 step borrow
      load(10, 10);
      step_valid = 1'b1; step_ns = ADJ_W'(-30);
      tick();
      step_valid = 1'b0;
      chk("R5", "step borrow ns", longint'(tm_ns), 985);
      chk("R5", "step borrow sec", longint'(tm_sec), 9);
      chk("R5", "step borrow tick", longint'(sec_tick), 0);
      // R5 step rounding
      load(2, 100);
      step_valid = 1'b1; step_ns = ADJ_W'(7);
      tick();
      step_valid = 1'b0;
      chk("R5", "step rounded", longint'(tm_ns), 110);

      // R7/R8 pulse: period 123 -> 120 ns (24 cycles), width 12 -> 3 cycles
      pps_period = 32'd123; pps_width = 32'd12; pps_en = 1'b1;
      repeat (400) tick();
      chk("R8", "edge spacing 120ns", last_gap, 24);
      chk("R7", "high length 12ns", longint'(last_hi), 3);
      // R9 period below minimum, width above limit
      pps_period = 32'd10; pps_width = 32'd2000;
      repeat (200) tick();
      chk("R9", "period clamped low", last_gap, 10);
      chk("R9", "width clamped high", longint'(last_hi), 9);
      // R9 period above maximum, width zero
      pps_period = 32'd3000; pps_width = 32'd0;
      repeat (700) tick();
      chk("R9", "period clamped high", last_gap, 200);
      chk("R9", "width clamped low", longint'(last_hi), 1);

      // R10 disable
      pps_en = 1'b0;
      tick();
      chk("R10", "pulse low after disable", longint'(pps_out), 0);
      r0 = rises;
      repeat (400) tick();
      chk("R10", "no pulse while disabled", rises, r0);

      // R1/R4 reset clears set_done
      rst_n = 1'b0;
      tick();
      chk("R1", "set_done after reset", longint'(set_done), 0);
      chk("R1", "ns after reset", longint'(tm_ns), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule